// File: doc/BRIEF.md
# Sampling Converter Start-and-Read Sequencer

This block sits on the host side of a 12-bit sampling converter that has a parallel result port. After reset it waits a fixed settling period. It then turns each trigger request into one start pulse on the converter's active-low start line. The start pulses are spaced so that two of them never come closer than a configured minimum. The block waits for the converter's end-of-conversion flag. It then lowers the converter's select line, waits a setup time, lowers the read-enable line and captures the result.

The converter can be strapped for a full 12-bit bus or for a narrow 8-bit bus. On the narrow bus only the upper eight data lines carry data. The result arrives in two steps, the upper byte first, and a byte-select output chooses which byte is shown. A justify output tells the converter how to place the 12 bits across the two bytes. The block joins the bytes, extends the 12-bit value to 16 bits and presents it for one cycle on a valid strobe. The extension is with zeros for straight binary and with the sign bit for two's complement. Each time interval is a parameter counted in clock cycles.

A conversion whose end flag never rises is abandoned after a timeout. The block raises a one-cycle error pulse and returns to idle. A trigger that arrives while the block is busy is held as one pending request.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is high, `adc_sc_n`, `adc_cs_n` and `adc_oe_n` are high and `res_valid` and `err_timeout` are low. After reset is released, no start pulse begins until at least PWRUP_CYC cycles have passed.
- R2: Each start pulse holds `adc_sc_n` low for exactly SC_PULSE_CYC cycles. The falling edges of two successive start pulses are at least START_GAP_CYC cycles apart.
- R3: A trigger seen while the block is busy or still in power-up is kept as a single pending request. Any number of such triggers during one busy period produce exactly one extra conversion.
- R4: `adc_oe_n` is low only while `adc_cs_n` is low. `adc_cs_n` goes low at least CS_SETUP_CYC cycles before `adc_oe_n` goes low.
- R5: `adc_cs_n` goes low only once `adc_eoc` is high after a start pulse. `adc_cs_n` is high for the whole of each start pulse.
- R6: At least RECOVER_CYC cycles pass between `adc_oe_n` returning high and the next falling edge of `adc_sc_n`.
- R7: In word mode (`mode_word` = 1 at the start), `adc_oe_n` is low for exactly OE_DATA_CYC cycles and `adc_hbe` stays low. The 12-bit value on `adc_data[11:0]` is captured in the last of those cycles.
- R8: In byte mode (`mode_word` = 0), `adc_oe_n` stays low for 2×OE_DATA_CYC cycles. `adc_hbe` is high for the first OE_DATA_CYC of those cycles and low for the second. A byte is taken from `adc_data[11:4]` at the end of each half. `adc_data[3:0]` is ignored.
- R9: In byte mode, `adc_left` is driven from `just_left`. With it at 1, the result is {high byte, low byte[7:4]}. With it at 0, the result is {high byte[3:0], low byte}.
- R10: With `bipolar` = 0, `res_data[15:12]` is zero. With `bipolar` = 1, `res_data[15:12]` repeats bit 11 of the result.
- R11: Each completed read raises `res_valid` for exactly one cycle. `mode_word`, `just_left` and `bipolar` are sampled in the cycle the start is issued. Changes to them later in the conversion have no effect on that result.
- R12: If `adc_eoc` is not high within EOC_TIMEOUT_CYC cycles after the start pulse ends, `err_timeout` pulses for one cycle. In that case no read is made, no result is produced and the block returns to idle, where it accepts triggers again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Request one conversion |
| mode_word | input | 1 | 1: 12-bit word read, 0: two-byte read |
| just_left | input | 1 | Byte mode: 1 left-justified, 0 right-justified |
| bipolar | input | 1 | 1: two's complement result, 0: straight binary |
| adc_sc_n | output | 1 | Start-of-conversion, active low |
| adc_eoc | input | 1 | End-of-conversion flag from the converter |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_oe_n | output | 1 | Converter read enable, active low |
| adc_hbe | output | 1 | Byte mode: high shows upper byte |
| adc_left | output | 1 | Byte mode: justify select to the converter |
| adc_data | input | 12 | Converter data lines |
| res_data | output | 16 | Extended result |
| res_valid | output | 1 | One-cycle result strobe |
| err_timeout | output | 1 | One-cycle end-of-conversion timeout pulse |

## Verification
The bench triggers during power-up and sends bursts of triggers while a conversion is in progress. A design without the pending latch would lose a conversion, and one that counted triggers would run extra ones. A converter model places the bytes according to the justify and byte-select lines and puts junk on the four unused low lines. A wrong byte order, a swapped justification or reading those low lines then shows up as a data mismatch in the scoreboard. The bench uses results at the sign boundary (0x7FF, 0x800) to catch a missing or wrong extension. It changes the mode inputs in the middle of a conversion to catch mode selects that are not latched at the start. Monitors measure each interval on the converter lines, so a block that issues starts too close together or skips the setup or recovery gap is caught. A converter model that never finishes checks that the block raises its error and does not hang.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;

    localparam int ADC_W  = 12;
    localparam int BYTE_W = 8;
    localparam int RES_W  = 16;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_START,
        ST_CONV,
        ST_SETUP,
        ST_READ,
        ST_RECOVER
    } ctl_state_e;

    typedef struct packed {
        logic word;
        logic left;
        logic bipolar;
    } rd_cfg_t;

    function automatic logic [ADC_W-1:0] join_bytes(
        input logic [BYTE_W-1:0] hi,
        input logic [BYTE_W-1:0] lo,
        input logic              left
    );
        if (left)
            return {hi, lo[BYTE_W-1 -: (ADC_W-BYTE_W)]};
        return {hi[(ADC_W-BYTE_W)-1:0], lo};
    endfunction

    function automatic logic [RES_W-1:0] extend_result(
        input logic [ADC_W-1:0] raw,
        input logic             bipolar
    );
        logic fill;
        fill = bipolar & raw[ADC_W-1];
        return {{(RES_W-ADC_W){fill}}, raw};
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
`timescale 1ns/1ps
module adc_rd_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= W'(RST_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/adc_rd_assemble.sv
`timescale 1ns/1ps
module adc_rd_assemble
    import adc_rd_pkg::*;
(
    input  rd_cfg_t           cfg,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic [ADC_W-1:0]  bus,
    output logic [RES_W-1:0]  result
);
    logic [ADC_W-1:0] raw;

    always_comb begin
        if (cfg.word)
            raw = bus;
        else
            raw = join_bytes(hi_byte, bus[ADC_W-1 -: BYTE_W], cfg.left);
        result = extend_result(raw, cfg.bipolar);
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int PWRUP_CYC       = 2000,
    parameter int START_GAP_CYC   = 1000,
    parameter int SC_PULSE_CYC    = 20,
    parameter int CS_SETUP_CYC    = 4,
    parameter int OE_DATA_CYC     = 6,
    parameter int RECOVER_CYC     = 40,
    parameter int EOC_TIMEOUT_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic              mode_word,
    input  logic              just_left,
    input  logic              bipolar,
    output logic              adc_sc_n,
    input  logic              adc_eoc,
    output logic              adc_cs_n,
    output logic              adc_oe_n,
    output logic              adc_hbe,
    output logic              adc_left,
    input  logic [ADC_W-1:0]  adc_data,
    output logic [RES_W-1:0]  res_data,
    output logic              res_valid,
    output logic              err_timeout
);
    localparam int MAX_A  = (PWRUP_CYC > EOC_TIMEOUT_CYC) ? PWRUP_CYC : EOC_TIMEOUT_CYC;
    localparam int MAX_B  = (RECOVER_CYC > SC_PULSE_CYC) ? RECOVER_CYC : SC_PULSE_CYC;
    localparam int MAX_C  = (CS_SETUP_CYC > OE_DATA_CYC) ? CS_SETUP_CYC : OE_DATA_CYC;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_ST = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int ST_W   = $clog2(MAX_ST + 1);
    localparam int GAP_W  = $clog2(START_GAP_CYC + 1);

    localparam logic [ST_W-1:0]  LD_SC   = ST_W'(SC_PULSE_CYC - 1);
    localparam logic [ST_W-1:0]  LD_TO   = ST_W'(EOC_TIMEOUT_CYC - 1);
    localparam logic [ST_W-1:0]  LD_CS   = ST_W'(CS_SETUP_CYC - 1);
    localparam logic [ST_W-1:0]  LD_OE   = ST_W'(OE_DATA_CYC - 1);
    localparam logic [ST_W-1:0]  LD_REC  = ST_W'(RECOVER_CYC - 1);
    localparam logic [GAP_W-1:0] LD_GAP  = GAP_W'(START_GAP_CYC - 1);

    ctl_state_e        state_q, state_d;
    rd_cfg_t           cfg_q;
    logic              pend_q;
    logic              hi_phase_q;
    logic [BYTE_W-1:0] hi_byte_q;
    logic [RES_W-1:0]  res_q;
    logic              valid_q, err_q;

    logic              st_load, st_done;
    logic [ST_W-1:0]   st_val;
    logic              gap_load, gap_done;
    logic              start_now, byte_turn;
    logic [RES_W-1:0]  assembled;

    adc_rd_timer #(.W(ST_W), .RST_VAL(PWRUP_CYC - 1)) u_st_tmr (
        .clk(clk), .rst(rst), .load(st_load), .load_val(st_val), .done(st_done)
    );

    adc_rd_timer #(.W(GAP_W), .RST_VAL(0)) u_gap_tmr (
        .clk(clk), .rst(rst), .load(gap_load), .load_val(LD_GAP), .done(gap_done)
    );

    adc_rd_assemble u_asm (
        .cfg(cfg_q), .hi_byte(hi_byte_q), .bus(adc_data), .result(assembled)
    );

    assign byte_turn = !cfg_q.word && hi_phase_q;

    always_comb begin
        state_d   = state_q;
        st_load   = 1'b0;
        st_val    = '0;
        gap_load  = 1'b0;
        start_now = 1'b0;
        unique case (state_q)
            ST_PWRUP: if (st_done) state_d = ST_IDLE;
            ST_IDLE: begin
                if ((trig || pend_q) && gap_done) begin
                    state_d   = ST_START;
                    st_load   = 1'b1;
                    st_val    = LD_SC;
                    gap_load  = 1'b1;
                    start_now = 1'b1;
                end
            end
            ST_START: begin
                if (st_done) begin
                    state_d = ST_CONV;
                    st_load = 1'b1;
                    st_val  = LD_TO;
                end
            end
            ST_CONV: begin
                if (adc_eoc) begin
                    state_d = ST_SETUP;
                    st_load = 1'b1;
                    st_val  = LD_CS;
                end else if (st_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SETUP: begin
                if (st_done) begin
                    state_d = ST_READ;
                    st_load = 1'b1;
                    st_val  = LD_OE;
                end
            end
            ST_READ: begin
                if (st_done) begin
                    st_load = 1'b1;
                    if (byte_turn) begin
                        st_val = LD_OE;
                    end else begin
                        state_d = ST_RECOVER;
                        st_val  = LD_REC;
                    end
                end
            end
            ST_RECOVER: if (st_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_PWRUP;
            cfg_q      <= '0;
            pend_q     <= 1'b0;
            hi_phase_q <= 1'b0;
            hi_byte_q  <= '0;
            res_q      <= '0;
            valid_q    <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            if (start_now) begin
                cfg_q  <= '{word: mode_word, left: just_left, bipolar: bipolar};
                pend_q <= 1'b0;
            end else if (trig) begin
                pend_q <= 1'b1;
            end
            if (state_q == ST_CONV) begin
                if (adc_eoc)
                    hi_phase_q <= 1'b1;
                else if (st_done)
                    err_q <= 1'b1;
            end
            if (state_q == ST_READ && st_done) begin
                hi_phase_q <= 1'b0;
                if (byte_turn) begin
                    hi_byte_q <= adc_data[ADC_W-1 -: BYTE_W];
                end else begin
                    res_q   <= assembled;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign adc_sc_n    = (state_q != ST_START);
    assign adc_cs_n    = !(state_q == ST_SETUP || state_q == ST_READ);
    assign adc_oe_n    = (state_q != ST_READ);
    assign adc_hbe     = byte_turn && !adc_cs_n;
    assign adc_left    = !cfg_q.word && cfg_q.left;
    assign res_data    = res_q;
    assign res_valid   = valid_q;
    assign err_timeout = err_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
`timescale 1ns/1ps
module adc_rd_ctrl_chk #(
    parameter int PWRUP_CYC     = 2000,
    parameter int START_GAP_CYC = 1000,
    parameter int RECOVER_CYC   = 40
) (
    input logic clk,
    input logic rst,
    input logic adc_sc_n,
    input logic adc_cs_n,
    input logic adc_oe_n,
    input logic adc_eoc,
    input logic res_valid,
    input logic err_timeout
);
    int   since_rst, since_sc, since_oe;
    logic sc_prev, oe_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
            since_sc  <= START_GAP_CYC;
            since_oe  <= RECOVER_CYC;
            sc_prev   <= 1'b1;
            oe_prev   <= 1'b1;
        end else begin
            sc_prev <= adc_sc_n;
            oe_prev <= adc_oe_n;
            if (since_rst < PWRUP_CYC) since_rst <= since_rst + 1;
            if (!adc_sc_n && sc_prev)          since_sc <= 1;
            else if (since_sc < START_GAP_CYC) since_sc <= since_sc + 1;
            if (adc_oe_n && !oe_prev)          since_oe <= 1;
            else if (since_oe < RECOVER_CYC)   since_oe <= since_oe + 1;
        end
    end

    AST_PWRUP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adc_sc_n |-> since_rst >= PWRUP_CYC); // R1
    AST_START_SPACING: assert property (@(posedge clk) disable iff (rst)
        (!adc_sc_n && sc_prev) |-> since_sc >= START_GAP_CYC); // R2
    AST_OE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
        !adc_oe_n |-> !adc_cs_n); // R4
    AST_READ_AFTER_EOC: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> adc_eoc); // R5
    AST_NO_CS_IN_START: assert property (@(posedge clk) disable iff (rst)
        !adc_sc_n |-> adc_cs_n); // R5
    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (rst)
        (!adc_sc_n && sc_prev) |-> since_oe >= RECOVER_CYC); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R11
    AST_TIMEOUT_CLEAN: assert property (@(posedge clk) disable iff (rst)
        err_timeout |-> (adc_cs_n && !res_valid)); // R12
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .PWRUP_CYC(PWRUP_CYC),
    .START_GAP_CYC(START_GAP_CYC),
    .RECOVER_CYC(RECOVER_CYC)
) u_chk (
    .clk(clk), .rst(rst), .adc_sc_n(adc_sc_n), .adc_cs_n(adc_cs_n),
    .adc_oe_n(adc_oe_n), .adc_eoc(adc_eoc), .res_valid(res_valid),
    .err_timeout(err_timeout)
);

// File: tb/adc_rd_ctrl_test.sv
`timescale 1ns/1ps
module adc_rd_ctrl_test;
    localparam int PW   = 40;
    localparam int GAP  = 30;
    localparam int SCP  = 3;
    localparam int CSS  = 2;
    localparam int OED  = 2;
    localparam int REC  = 5;
    localparam int TO   = 50;
    localparam int CONV = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0, mode_word = 1'b1, just_left = 1'b0, bipolar = 1'b0;
    logic        adc_sc_n, adc_cs_n, adc_oe_n, adc_hbe, adc_left;
    logic        adc_eoc;
    logic [11:0] adc_data;
    logic [15:0] res_data;
    logic        res_valid, err_timeout;

    always #2.5 clk = ~clk;

    adc_rd_ctrl #(
        .PWRUP_CYC(PW), .START_GAP_CYC(GAP), .SC_PULSE_CYC(SCP),
        .CS_SETUP_CYC(CSS), .OE_DATA_CYC(OED), .RECOVER_CYC(REC),
        .EOC_TIMEOUT_CYC(TO)
    ) uut (
        .clk(clk), .rst(rst), .trig(trig), .mode_word(mode_word),
        .just_left(just_left), .bipolar(bipolar), .adc_sc_n(adc_sc_n),
        .adc_eoc(adc_eoc), .adc_cs_n(adc_cs_n), .adc_oe_n(adc_oe_n),
        .adc_hbe(adc_hbe), .adc_left(adc_left), .adc_data(adc_data),
        .res_data(res_data), .res_valid(res_valid), .err_timeout(err_timeout)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // converter model
    logic [11:0] samp_q[$];
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [11:0] cur_s = '0;
    bit          drv_word = 1'b1;
    bit          hang = 1'b0;
    int          busy_cnt = 0;
    logic        sc_seen_high = 1'b1;

    always @(posedge clk) begin
        logic [11:0] t;
        if (rst) begin
            adc_eoc      <= 1'b1;
            busy_cnt     <= 0;
            sc_seen_high <= 1'b1;
        end else begin
            if (!adc_sc_n && sc_seen_high) begin
                adc_eoc <= 1'b0;
                t = (samp_q.size() > 0) ? samp_q.pop_front() : 12'h000;
                cur_s    <= t;
                busy_cnt <= hang ? 0 : CONV;
            end else if (busy_cnt > 0) begin
                busy_cnt <= busy_cnt - 1;
                if (busy_cnt == 1) adc_eoc <= 1'b1;
            end
            sc_seen_high <= adc_sc_n;
        end
    end

    always_comb begin
        if (!adc_cs_n && !adc_oe_n) begin
            if (drv_word)
                adc_data = cur_s;
            else if (adc_hbe)
                adc_data = {(adc_left ? cur_s[11:4] : {4'h0, cur_s[11:8]}), 4'h5};
            else
                adc_data = {(adc_left ? {cur_s[3:0], 4'h0} : cur_s[7:0]), 4'hA};
        end else begin
            adc_data = 12'hEEE;
        end
    end

    // scoreboard monitor
    int n_err_pulse = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected result", int'(res_data), 0);
                end else begin
                    logic [15:0] e;
                    string       tg;
                    e  = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    chk(res_data == e, tg, int'(res_data), int'(e));
                end
            end
            if (err_timeout) begin
                n_err_pulse++;
                chk(!res_valid, "R12 valid with error", int'(res_valid), 0);
            end
        end
    end

    // interface timing monitor
    int   cyc = 0, n_sc = 0, n_cs_fall = 0;
    int   last_sc = 0, last_oe_rise = -1, cs_fall = 0;
    int   hi_cyc = 0, lo_cyc = 0;
    bit   first_hbe = 1'b0;
    logic p_sc = 1'b1, p_cs = 1'b1, p_oe = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (p_sc && !adc_sc_n) begin
                n_sc++;
                if (n_sc == 1) chk(cyc >= PW, "R1 power-up wait", cyc, PW);
                else           chk(cyc - last_sc >= GAP, "R2 start spacing", cyc - last_sc, GAP);
                if (last_oe_rise >= 0)
                    chk(cyc - last_oe_rise >= REC, "R6 recovery", cyc - last_oe_rise, REC);
                last_sc = cyc;
            end
            if (!p_sc && adc_sc_n)
                chk(cyc - last_sc == SCP, "R2 pulse width", cyc - last_sc, SCP);
            if (p_cs && !adc_cs_n) begin
                n_cs_fall++;
                cs_fall = cyc;
                chk(adc_eoc == 1'b1, "R5 select before end flag", int'(adc_eoc), 1);
            end
            if (p_oe && !adc_oe_n) begin
                chk(cyc - cs_fall >= CSS, "R4 select setup", cyc - cs_fall, CSS);
                hi_cyc = 0;
                lo_cyc = 0;
                first_hbe = adc_hbe;
            end
            if (!adc_oe_n) begin
                if (adc_hbe) hi_cyc++;
                else         lo_cyc++;
            end
            if (!p_oe && adc_oe_n) begin
                last_oe_rise = cyc;
                if (drv_word) begin
                    chk(hi_cyc == 0 && lo_cyc == OED, "R7 word read window", lo_cyc, OED);
                end else begin
                    chk(first_hbe && hi_cyc == OED && lo_cyc == OED,
                        "R8 byte read windows", hi_cyc * 256 + lo_cyc, OED * 256 + OED);
                end
            end
            p_sc = adc_sc_n;
            p_cs = adc_cs_n;
            p_oe = adc_oe_n;
        end
    end

    // driver
    task automatic pulse_trig();
        @(negedge clk) trig = 1'b1;
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic push_conv(input logic [11:0] s, input bit wd, input bit bp, input string tg);
        samp_q.push_back(s);
        exp_q.push_back(bp ? {{4{s[11]}}, s} : {4'h0, s});
        tag_q.push_back(tg);
        drv_word = wd;
    endtask

    task automatic wait_sc_low();
        while (adc_sc_n) @(negedge clk);
    endtask

    task automatic wait_empty();
        while (exp_q.size() > 0) @(negedge clk);
        repeat (GAP + 10) @(negedge clk);
    endtask

    task automatic do_conv(input logic [11:0] s, input bit wd, input bit lj,
                           input bit bp, input bit scramble, input string tg);
        mode_word = wd;
        just_left = lj;
        bipolar   = bp;
        push_conv(s, wd, bp, tg);
        pulse_trig();
        wait_sc_low();
        if (scramble) begin
            @(negedge clk);
            mode_word = ~wd;
            just_left = ~lj;
            bipolar   = ~bp;
        end
        wait_empty();
    endtask

    // watchdog
    int wd_cnt = 0;
    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<%0d", wd_cnt, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int sc_before, cs_before, err_before;
        repeat (3) @(negedge clk);
        chk(adc_sc_n && adc_cs_n && adc_oe_n, "R1 reset lines", {adc_sc_n, adc_cs_n, adc_oe_n}, 7);
        chk(!res_valid && !err_timeout, "R1 reset strobes", {res_valid, err_timeout}, 0);
        rst = 1'b0;

        // trigger during power-up is held pending (R3), word read unipolar
        do_conv(12'hABC, 1'b1, 1'b0, 1'b0, 1'b0, "R7 word unipolar");
        do_conv(12'h9F3, 1'b1, 1'b0, 1'b1, 1'b1, "R11 latched word bipolar");
        do_conv(12'h5A7, 1'b0, 1'b1, 1'b0, 1'b1, "R9 left justify");
        do_conv(12'h8C1, 1'b0, 1'b0, 1'b1, 1'b0, "R9 right justify bipolar");
        do_conv(12'h7FF, 1'b0, 1'b1, 1'b1, 1'b0, "R10 largest positive");
        do_conv(12'h800, 1'b0, 1'b0, 1'b1, 1'b1, "R10 most negative");
        do_conv(12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0, "R10 unipolar full scale");

        // burst of triggers: one pending extra conversion (R3)
        sc_before = n_sc;
        mode_word = 1'b0; just_left = 1'b1; bipolar = 1'b0;
        push_conv(12'h3C6, 1'b0, 1'b0, "R3 first of burst");
        push_conv(12'hC39, 1'b0, 1'b0, "R3 pending conversion");
        pulse_trig();
        wait_sc_low();
        pulse_trig();
        pulse_trig();
        wait_empty();
        repeat (3 * GAP) @(negedge clk);
        chk(n_sc - sc_before == 2, "R3 pending count", n_sc - sc_before, 2);

        // end flag never rises (R12)
        sc_before  = n_sc;
        cs_before  = n_cs_fall;
        err_before = n_err_pulse;
        hang = 1'b1;
        pulse_trig();
        repeat (TO + GAP) @(negedge clk);
        chk(n_err_pulse - err_before == 1, "R12 error pulse", n_err_pulse - err_before, 1);
        chk(n_cs_fall == cs_before, "R12 no read on timeout", n_cs_fall - cs_before, 0);
        chk(n_sc - sc_before == 1, "R12 single start", n_sc - sc_before, 1);
        hang = 1'b0;
        do_conv(12'h2D4, 1'b1, 1'b0, 1'b1, 1'b0, "R12 recovery after timeout");

        repeat (50) @(negedge clk);
        chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule